// File: doc/BRIEF.md
# Cartridge Bank Controller

This block sits between an 8-bit processor bus with a 16-bit address and a banked cartridge ROM and RAM. Processor writes that land in the lower half of the address map (0x0000–0x7FFF) do not reach ROM. They are decoded as commands to the controller. One command gates the external RAM on or off. One loads a 7-bit ROM bank number. One selects either a RAM bank or one of the clock registers. The block turns the processor address into a physical ROM address for the fixed and switchable ROM windows. It also turns it into a physical RAM address for the external RAM window at 0xA000–0xBFFF, and it returns the byte that a read of that window must deliver.

A separate combinational decoder turns three cartridge header bytes into three results: a controller family code, a ROM bank count and a RAM size in kilobytes. Each result has a flag that says whether its code was recognised. There is no clock counter, so the clock registers always read back as zero. The storage arrays are outside the block.

No data stream passes through the block, so every pin is a plain level. Address translation is combinational. Command writes take effect at the clock edge that samples `bus_we`.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank register is 1, the select register is 0 and RAM access is disabled.
- R2: For an address in 0x0000–0x3FFF, `rom_cs` is 1 and `rom_addr` equals the address, which is bank 0.
- R3: For an address in 0x4000–0x7FFF, `rom_addr` equals bank × 0x4000 + address[13:0]. A stored bank value of 0 is used as bank 1.
- R4: A write in 0x0000–0x1FFF with data 0x0A enables RAM access. Data 0x00 disables it. Any other data leaves the enable unchanged.
- R5: A write in 0x2000–0x3FFF loads the ROM bank register with data[6:0].
- R6: A write in 0x4000–0x5FFF with data 0x00–0x03 selects that RAM bank. Data 0x08–0x0C selects a clock register. Any other data leaves the selection unchanged.
- R7: When RAM access is enabled and a RAM bank is selected, an address in 0xA000–0xBFFF gives the following: `ram_cs` is 1, `ram_addr` equals bank × 0x2000 + (address − 0xA000), `ram_we` follows `bus_we`, and `win_rdata` equals `ram_rdata`.
- R8: When RAM access is enabled and a clock register is selected, the RAM window reads 0x00, and `ram_cs` and `ram_we` stay 0.
- R9: When RAM access is disabled, the RAM window reads 0xFF, and `ram_cs` and `ram_we` stay 0. Outside the window, `win_rdata` is 0xFF.
- R10: Writes in 0x6000–0x7FFF, which would latch the clock, change no register.
- R11: ROM-size code 0x00 gives 2 banks. A code n in 0x01–0x07 gives 2^(n+1) banks. Codes 0x52, 0x53 and 0x54 give 72, 80 and 96 banks. Any other code gives 0 with `hdr_rom_ok` = 0.
- R12: RAM-size codes 0x00–0x03 give 0, 2, 8 and 32 KB. Any other code gives 0 with `hdr_ram_ok` = 0.
- R13: The type code maps to a family as follows. Code 0x00, 0x08 or 0x09 gives 0 (ROM only). Codes 0x01–0x03 give 1. Codes 0x05–0x06 give 2. Codes 0x0F–0x13 give 3, which is the banked controller built here. Code 0xFF gives 4. Any other code gives 7 with `hdr_type_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| bus_we | input | 1 | Processor write strobe |
| ram_rdata | input | 8 | Read data from the external RAM array |
| rom_addr | output | 21 | Physical ROM address |
| rom_cs | output | 1 | Address falls in ROM space |
| ram_addr | output | 15 | Physical RAM address |
| ram_cs | output | 1 | RAM array access enabled |
| ram_we | output | 1 | RAM array write strobe |
| win_rdata | output | 8 | Byte returned for a RAM-window read |
| hdr_type | input | 8 | Header controller-type byte |
| hdr_rom | input | 8 | Header ROM-size byte |
| hdr_ram | input | 8 | Header RAM-size byte |
| hdr_family | output | 3 | Decoded controller family |
| hdr_type_ok | output | 1 | Type code recognised |
| hdr_rom_banks | output | 9 | ROM bank count |
| hdr_rom_ok | output | 1 | ROM-size code recognised |
| hdr_ram_kb | output | 6 | RAM size in KB |
| hdr_ram_ok | output | 1 | RAM-size code recognised |

## Verification
The address and data outputs settle in the same cycle that an address is presented, with no register on the way. The bench therefore drives each probe on the falling edge and samples one time unit later, before the next rising edge. A command write is sampled at one rising edge and is visible from then on. The bench updates its model at that edge and probes from the following falling edge. The header outputs are combinational and are checked one time unit after each code is applied.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [2:0] {
    FAM_ROM_ONLY = 3'd0,
    FAM_ONE      = 3'd1,
    FAM_TWO      = 3'd2,
    FAM_THREE    = 3'd3,
    FAM_FOUR     = 3'd4,
    FAM_UNKNOWN  = 3'd7
  } family_e;

  localparam int unsigned ROM_OFS_W = 14;  // 16 KB ROM window
  localparam int unsigned RAM_OFS_W = 13;  // 8 KB RAM window
  localparam int unsigned SEL_W     = 4;   // holds 0x00..0x0C
endpackage

// File: rtl/cbc_regs.sv
module cbc_regs #(
  parameter int unsigned ROM_BANK_W = 7,
  parameter int unsigned RAM_BANK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            region,
  input  logic [7:0]            wdata,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  clk_mode,
  output logic                  ram_on
);
  import cbc_pkg::*;

  logic [SEL_W-1:0] sel_q;
  logic             sel_legal;

  assign sel_legal = (wdata <= 8'h03) || (wdata >= 8'h08 && wdata <= 8'h0C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_bank <= ROM_BANK_W'(1);
      sel_q    <= '0;
      ram_on   <= 1'b0;
    end else if (wr_en) begin
      unique case (region)
        3'b000: begin
          if (wdata == 8'h0A)      ram_on <= 1'b1;
          else if (wdata == 8'h00) ram_on <= 1'b0;
        end
        3'b001: rom_bank <= wdata[ROM_BANK_W-1:0];
        3'b010: if (sel_legal) sel_q <= wdata[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  assign ram_bank = sel_q[RAM_BANK_W-1:0];
  assign clk_mode = sel_q[SEL_W-1];
endmodule

// File: rtl/cbc_xlate.sv
module cbc_xlate #(
  parameter int unsigned ROM_BANK_W = 7,
  parameter int unsigned RAM_BANK_W = 2,
  localparam int unsigned ROM_AW = ROM_BANK_W + cbc_pkg::ROM_OFS_W,
  localparam int unsigned RAM_AW = RAM_BANK_W + cbc_pkg::RAM_OFS_W
) (
  input  logic [15:0]           addr,
  input  logic                  we,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  input  logic                  clk_mode,
  input  logic                  ram_on,
  input  logic [7:0]            ram_rdata,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic                  rom_cs,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic                  ram_cs,
  output logic                  ram_we,
  output logic [7:0]            win_rdata
);
  import cbc_pkg::*;

  logic [ROM_BANK_W-1:0] eff_bank;
  logic                  in_win;

  assign eff_bank = (rom_bank == '0) ? ROM_BANK_W'(1) : rom_bank;
  assign rom_cs   = ~addr[15];
  assign rom_addr = addr[14] ? {eff_bank, addr[ROM_OFS_W-1:0]}
                             : {{ROM_BANK_W{1'b0}}, addr[ROM_OFS_W-1:0]};

  assign in_win   = (addr[15:13] == 3'b101);
  assign ram_cs   = in_win & ram_on & ~clk_mode;
  assign ram_we   = ram_cs & we;
  assign ram_addr = {ram_bank, addr[RAM_OFS_W-1:0]};

  always_comb begin
    if (!in_win || !ram_on) win_rdata = 8'hFF;
    else if (clk_mode)      win_rdata = 8'h00;
    else                    win_rdata = ram_rdata;
  end
endmodule

// File: rtl/cbc_hdr.sv
module cbc_hdr (
  input  logic [7:0] type_code,
  input  logic [7:0] rom_code,
  input  logic [7:0] ram_code,
  output logic [2:0] family,
  output logic       type_ok,
  output logic [8:0] rom_banks,
  output logic       rom_ok,
  output logic [5:0] ram_kb,
  output logic       ram_ok
);
  import cbc_pkg::*;

  always_comb begin
    type_ok = 1'b1;
    if (type_code == 8'h00 || type_code == 8'h08 || type_code == 8'h09)
      family = FAM_ROM_ONLY;
    else if (type_code >= 8'h01 && type_code <= 8'h03) family = FAM_ONE;
    else if (type_code == 8'h05 || type_code == 8'h06) family = FAM_TWO;
    else if (type_code >= 8'h0F && type_code <= 8'h13) family = FAM_THREE;
    else if (type_code == 8'hFF)                        family = FAM_FOUR;
    else begin
      family  = FAM_UNKNOWN;
      type_ok = 1'b0;
    end
  end

  always_comb begin
    rom_ok = 1'b1;
    if (rom_code <= 8'h07)      rom_banks = 9'd2 << rom_code[2:0];
    else if (rom_code == 8'h52) rom_banks = 9'd72;
    else if (rom_code == 8'h53) rom_banks = 9'd80;
    else if (rom_code == 8'h54) rom_banks = 9'd96;
    else begin
      rom_banks = '0;
      rom_ok    = 1'b0;
    end
  end

  always_comb begin
    ram_ok = 1'b1;
    unique case (ram_code)
      8'h00:   ram_kb = 6'd0;
      8'h01:   ram_kb = 6'd2;
      8'h02:   ram_kb = 6'd8;
      8'h03:   ram_kb = 6'd32;
      default: begin ram_kb = 6'd0; ram_ok = 1'b0; end
    endcase
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int unsigned ROM_BANK_W = 7,
  parameter int unsigned RAM_BANK_W = 2,
  localparam int unsigned ROM_AW = ROM_BANK_W + cbc_pkg::ROM_OFS_W,
  localparam int unsigned RAM_AW = RAM_BANK_W + cbc_pkg::RAM_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic [7:0]        ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [7:0]        win_rdata,
  input  logic [7:0]        hdr_type,
  input  logic [7:0]        hdr_rom,
  input  logic [7:0]        hdr_ram,
  output logic [2:0]        hdr_family,
  output logic              hdr_type_ok,
  output logic [8:0]        hdr_rom_banks,
  output logic              hdr_rom_ok,
  output logic [5:0]        hdr_ram_kb,
  output logic              hdr_ram_ok
);
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic                  clk_mode;
  logic                  ram_on;
  logic                  cmd_we;

  assign cmd_we = bus_we & ~bus_addr[15];

  cbc_regs #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd_we), .region(bus_addr[15:13]),
    .wdata(bus_wdata), .rom_bank(rom_bank), .ram_bank(ram_bank),
    .clk_mode(clk_mode), .ram_on(ram_on)
  );

  cbc_xlate #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_xlate (
    .addr(bus_addr), .we(bus_we), .rom_bank(rom_bank), .ram_bank(ram_bank),
    .clk_mode(clk_mode), .ram_on(ram_on), .ram_rdata(ram_rdata),
    .rom_addr(rom_addr), .rom_cs(rom_cs), .ram_addr(ram_addr),
    .ram_cs(ram_cs), .ram_we(ram_we), .win_rdata(win_rdata)
  );

  cbc_hdr u_hdr (
    .type_code(hdr_type), .rom_code(hdr_rom), .ram_code(hdr_ram),
    .family(hdr_family), .type_ok(hdr_type_ok), .rom_banks(hdr_rom_banks),
    .rom_ok(hdr_rom_ok), .ram_kb(hdr_ram_kb), .ram_ok(hdr_ram_ok)
  );

  // R5
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[15:13] == 3'b001) |=> (rom_bank == $past(bus_wdata[ROM_BANK_W-1:0])));

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[15:13] == 3'b011) |=>
      ($stable(rom_bank) && $stable(ram_bank) && $stable(clk_mode) && $stable(ram_on)));

  // R4
  enable_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[15:13] == 3'b000 && bus_wdata == 8'h0A) |=> ram_on);

  // R9
  off_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_on && bus_addr[15:13] == 3'b101) |-> (win_rdata == 8'hFF && !ram_cs && !ram_we));

  // R8
  clk_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_on && clk_mode && bus_addr[15:13] == 3'b101) |-> (win_rdata == 8'h00 && !ram_we));

  // R3
  bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:14] == 2'b01) |-> (rom_addr[ROM_AW-1 -: ROM_BANK_W] != '0));
endmodule

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  ram_rdata = '0;
  logic [20:0] rom_addr;
  logic        rom_cs;
  logic [14:0] ram_addr;
  logic        ram_cs, ram_we;
  logic [7:0]  win_rdata;
  logic [7:0]  hdr_type = '0, hdr_rom = '0, hdr_ram = '0;
  logic [2:0]  hdr_family;
  logic        hdr_type_ok, hdr_rom_ok, hdr_ram_ok;
  logic [8:0]  hdr_rom_banks;
  logic [5:0]  hdr_ram_kb;

  int tests = 0, fails = 0;
  logic [6:0] m_bank;
  logic [3:0] m_sel;
  logic       m_en;

  always #(CLK_P/2) clk = ~clk;

  cart_bank_ctrl u0 (.*);

  task automatic chk(string tag, longint got, longint exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [20:0] exp_rom(logic [15:0] a);
    logic [6:0] b = (m_bank == 0) ? 7'd1 : m_bank;
    return a[14] ? {b, a[13:0]} : {7'd0, a[13:0]};
  endfunction

  function automatic logic [7:0] exp_win(logic [15:0] a, logic [7:0] rd);
    if (a[15:13] != 3'b101 || !m_en) return 8'hFF;
    if (m_sel >= 4'd8) return 8'h00;
    return rd;
  endfunction

  function automatic logic exp_cs(logic [15:0] a);
    return a[15:13] == 3'b101 && m_en && m_sel < 4'd8;
  endfunction

  task automatic model_wr(logic [15:0] a, logic [7:0] d);
    case (a[15:13])
      3'b000: if (d == 8'h0A) m_en = 1'b1; else if (d == 8'h00) m_en = 1'b0;
      3'b001: m_bank = d[6:0];
      3'b010: if (d <= 8'h03 || (d >= 8'h08 && d <= 8'h0C)) m_sel = d[3:0];
      default: ;
    endcase
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    model_wr(a, d);
    #1 bus_we = 1'b0;
  endtask

  // probe: combinational outputs sampled 1 unit after drive, before next edge
  task automatic probe(logic [15:0] a, logic we);
    logic [7:0] rd = 8'($urandom);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = 8'h5A; ram_rdata = rd;
    #1;
    chk("R2/R3 rom_cs", rom_cs, !a[15]);
    if (!a[15]) chk(a[14] ? "R3 rom_addr" : "R2 rom_addr", rom_addr, exp_rom(a));
    chk("R7/R8/R9 ram_cs", ram_cs, exp_cs(a));
    chk("R7/R8/R9 ram_we", ram_we, exp_cs(a) && we);
    chk("R7/R8/R9 win_rdata", win_rdata, exp_win(a, rd));
    if (exp_cs(a)) chk("R7 ram_addr", ram_addr, {m_sel[1:0], a[12:0]});
    @(posedge clk); #1 bus_we = 1'b0;
  endtask

  function automatic logic [15:0] rnd_win();
    return 16'hA000 | 16'($urandom_range(0, 16'h1FFF));
  endfunction

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog R1 got=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    m_bank = 7'd1; m_sel = 4'd0; m_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state through the ports
    probe(16'h4000, 1'b0);
    chk("R1 bank=1", rom_addr[20:14], 7'd1);
    probe(16'hA123, 1'b0);
    chk("R1 disabled", win_rdata, 8'hFF);
    // R4: enable, odd value ignored, disable
    wr(16'h0000, 8'h0A); probe(16'hA010, 1'b1);
    chk("R4 enabled", ram_cs, 1'b1);
    wr(16'h1FFF, 8'h55); probe(16'hA011, 1'b0);
    chk("R4 unchanged", ram_cs, 1'b1);
    wr(16'h1000, 8'h00); probe(16'hA012, 1'b1);
    chk("R4 disabled", ram_cs, 1'b0);
    // R3: bank 0 reads as bank 1; R5: upper bit dropped
    wr(16'h2000, 8'h00); probe(16'h7FFF, 1'b0);
    chk("R3 bank0->1", rom_addr, 21'h07FFF);
    wr(16'h3FFF, 8'hFF); probe(16'h4001, 1'b0);
    chk("R5 7-bit", rom_addr, {7'h7F, 14'h0001});
    // R6/R8: clock select and illegal value
    wr(16'h0000, 8'h0A);
    wr(16'h4000, 8'h0C); probe(16'hBFFF, 1'b1);
    chk("R8 clock read", win_rdata, 8'h00);
    wr(16'h5FFF, 8'h07); probe(16'hBFFE, 1'b0);
    chk("R6 illegal kept", win_rdata, 8'h00);
    wr(16'h4000, 8'h03); probe(16'hA000, 1'b0);
    chk("R6/R7 bank3", ram_addr, 15'h6000);
    // R10: latch writes leave state alone
    wr(16'h2000, 8'h15);
    wr(16'h6000, 8'h00); wr(16'h7FFF, 8'h01);
    probe(16'h4000, 1'b0);
    chk("R10 bank held", rom_addr[20:14], 7'h15);
    probe(16'hA001, 1'b0);
    chk("R10 ram held", ram_cs, 1'b1);
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int k = $urandom_range(0, 9);
      logic [7:0] d;
      case ($urandom_range(0, 4))
        0: d = 8'h0A; 1: d = 8'h00;
        2: d = 8'($urandom_range(0, 3)); 3: d = 8'($urandom_range(8, 12));
        default: d = 8'($urandom);
      endcase
      if (k < 4) wr(16'($urandom_range(0, 16'h7FFF)), d);
      else if (k < 7) probe(16'($urandom), 1'b0);
      else probe(rnd_win(), 1'($urandom));
    end
    // R11/R12/R13: header decode, every code
    for (int c = 0; c < 256; c++) begin
      logic [8:0] eb; logic eok; logic [5:0] ek; logic [2:0] ef;
      hdr_type = 8'(c); hdr_rom = 8'(c); hdr_ram = 8'(c);
      #1;
      eok = 1'b1;
      if (c <= 7) eb = 9'(2 << c);
      else if (c == 'h52) eb = 9'd72;
      else if (c == 'h53) eb = 9'd80;
      else if (c == 'h54) eb = 9'd96;
      else begin eb = 0; eok = 1'b0; end
      chk("R11 banks", hdr_rom_banks, eb); chk("R11 ok", hdr_rom_ok, eok);
      case (c) 0: ek = 0; 1: ek = 2; 2: ek = 8; 3: ek = 32; default: ek = 0; endcase
      chk("R12 kb", hdr_ram_kb, ek); chk("R12 ok", hdr_ram_ok, c <= 3);
      if (c == 0 || c == 8 || c == 9) ef = 0;
      else if (c >= 1 && c <= 3) ef = 1;
      else if (c == 5 || c == 6) ef = 2;
      else if (c >= 'h0F && c <= 'h13) ef = 3;
      else if (c == 'hFF) ef = 4;
      else ef = 7;
      chk("R13 family", hdr_family, ef); chk("R13 ok", hdr_type_ok, ef != 7);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule